// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits in front of the command path of a byte-wide flash core. It watches a synchronous stream of write strobes, each carrying a 15-bit address and an 8-bit data byte. It recognises three-write command sequences. Every sequence opens with the same two key writes: 0xAA to address 0x5555, then 0x55 to address 0x2AAA. The third write then selects one of three outcomes. It can grant a single protected sector-program operation. It can switch the product-identification mode on. It can switch that mode off.

A write that does not extend a valid sequence stores nothing and raises a one-cycle unauthorised-write pulse. Such a write also starts the internal write timer, and so do the identification commands. While that timer runs, further writes are dropped and reads report a status poll. In identification mode, reads at the two lowest addresses return fixed manufacturer and device codes. A granted program operation hands the write stream to the sector loader until that loader signals the end of its program cycle. Protection then takes over again by itself.

Top module: `flash_unlock_decoder`

## Requirements
- R1: After reset, `id_mode`, `prog_go`, `bad_write`, `busy`, `rd_valid`, `rd_poll` and `rd_id_hit` are all 0.
- R2: The writes 0xAA@0x5555, then 0x55@0x2AAA, then 0xA0@0x5555 raise `prog_go` for exactly one cycle. The pulse falls in the cycle after the third write.
- R3: After `prog_go`, writes belong to the sector loader. They raise neither `bad_write` nor `busy` and are not decoded, until `prog_end` is seen. After that, a lone 0xA0@0x5555 write is unauthorised again.
- R4: A third write of 0x90@0x5555 sets `id_mode`. A third write of 0xF0@0x5555 clears it. The level changes in the cycle after the third write.
- R5: A read (`rd_en`) in identification mode, with the timer idle and `rd_addr[14:1]` zero, returns `rd_id_hit`=1 one cycle later. The data is 0x1F when `rd_addr[0]`=0 and 0x3D when `rd_addr[0]`=1. Any other read returns `rd_id_hit`=0 and `rd_data`=0.
- R6: A wrong address or data at any of the three steps raises `bad_write` for one cycle, in the cycle after the write. The sequence then restarts from its first step.
- R7: An identification command or an unauthorised write holds `busy` high for WAIT_CYCLES cycles, starting in the next cycle. Writes made while `busy` is high are ignored. They raise no pulse and change no state.
- R8: A read made while `busy` is high returns `rd_poll`=1 and `rd_id_hit`=0.
- R9: Reset (loss of power) clears `id_mode`. It does not grant programming, so 0xA0@0x5555 written alone after reset is unauthorised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| prog_end | input | 1 | Sector loader reports that the program cycle has ended |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 15 | Read address |
| prog_go | output | 1 | One-cycle grant of one sector-program operation |
| id_mode | output | 1 | Identification mode active |
| bad_write | output | 1 | One-cycle unauthorised-write pulse |
| busy | output | 1 | Write timer running |
| rd_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| rd_poll | output | 1 | Read was a status poll |
| rd_id_hit | output | 1 | Read returned an identification code |
| rd_data | output | 8 | Identification code, or 0 |

## Verification
The embedded assertions check four things on every cycle. `prog_go` is never wider than one cycle. A write made under `busy` never produces a pulse and never moves `id_mode`. `busy` rises only from a timer start, and every start raises it. An identification hit never coincides with a poll, and it only follows an idle timer in identification mode. Only the bench's scenarios can show the rest. These are the exact key triplets and the outcome each third write selects, and the restart after a wrong step. They also cover the length of the busy window, the code values at each read address, the hand-off to the loader and back, and the effect of reset on the mode.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int ADDR_W = 15;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [DATA_W-1:0] KEY_DATA_1 = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_DATA_2 = 8'h55;
  localparam logic [DATA_W-1:0] OP_CODE_PROG   = 8'hA0;
  localparam logic [DATA_W-1:0] OP_CODE_ID_ON  = 8'h90;
  localparam logic [DATA_W-1:0] OP_CODE_ID_OFF = 8'hF0;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_KEY1  = 2'd1,
    SEQ_KEY2  = 2'd2,
    SEQ_OWNED = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_INVALID = 2'd0,
    OP_PROG    = 2'd1,
    OP_ID_ON   = 2'd2,
    OP_ID_OFF  = 2'd3
  } cmd_op_e;
endpackage

// File: rtl/fcd_cmd_matcher.sv
module fcd_cmd_matcher
  import fcd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              key1_ok,
  output logic              key2_ok,
  output cmd_op_e           op
);
  logic at_a;

  always_comb begin
    at_a    = (addr == KEY_ADDR_A);
    key1_ok = at_a && (data == KEY_DATA_1);
    key2_ok = (addr == KEY_ADDR_B) && (data == KEY_DATA_2);
    op      = OP_INVALID;
    if (at_a) begin
      case (data)
        OP_CODE_PROG:   op = OP_PROG;
        OP_CODE_ID_ON:  op = OP_ID_ON;
        OP_CODE_ID_OFF: op = OP_ID_OFF;
        default:        op = OP_INVALID;
      endcase
    end
  end
endmodule

// File: rtl/fcd_wait_timer.sv
module fcd_wait_timer #(
  parameter int WAIT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAIT_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (start)                cnt_d = CNT_LOAD;
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  assert_start_sets_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_busy_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_valid,
  input  logic    busy,
  input  logic    key1_ok,
  input  logic    key2_ok,
  input  cmd_op_e op,
  input  logic    prog_end,
  output logic    timer_start,
  output logic    prog_go,
  output logic    bad_write,
  output logic    id_mode
);
  seq_state_e state_q, state_d;
  logic       prog_q, prog_d;
  logic       bad_q, bad_d;
  logic       id_q, id_d;
  logic       accept;

  always_comb begin
    state_d     = state_q;
    prog_d      = 1'b0;
    bad_d       = 1'b0;
    id_d        = id_q;
    timer_start = 1'b0;
    accept      = wr_valid && !busy;
    if (state_q == SEQ_OWNED) begin
      if (prog_end) state_d = SEQ_IDLE;
    end else if (accept) begin
      case (state_q)
        SEQ_IDLE: begin
          if (key1_ok) state_d = SEQ_KEY1;
          else begin
            bad_d       = 1'b1;
            timer_start = 1'b1;
          end
        end
        SEQ_KEY1: begin
          if (key2_ok) state_d = SEQ_KEY2;
          else begin
            state_d     = SEQ_IDLE;
            bad_d       = 1'b1;
            timer_start = 1'b1;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          case (op)
            OP_PROG: begin
              prog_d  = 1'b1;
              state_d = SEQ_OWNED;
            end
            OP_ID_ON: begin
              id_d        = 1'b1;
              timer_start = 1'b1;
            end
            OP_ID_OFF: begin
              id_d        = 1'b0;
              timer_start = 1'b1;
            end
            default: begin
              bad_d       = 1'b1;
              timer_start = 1'b1;
            end
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      prog_q  <= 1'b0;
      bad_q   <= 1'b0;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      prog_q  <= prog_d;
      bad_q   <= bad_d;
      id_q    <= id_d;
    end
  end

  assign prog_go   = prog_q;
  assign bad_write = bad_q;
  assign id_mode   = id_q;

  assert_prog_one_shot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> !prog_go);
  assert_owned_no_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_OWNED) |=> !bad_write && !prog_go);
  assert_id_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_mode) |-> $past(wr_valid));
  assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !bad_write && !prog_go && $stable(id_mode));
endmodule

// File: rtl/fcd_id_responder.sv
module fcd_id_responder
  import fcd_pkg::*;
#(
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              id_mode,
  input  logic              busy,
  output logic              rd_valid,
  output logic              rd_poll,
  output logic              rd_id_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic              valid_q, poll_q, hit_q;
  logic              poll_d, hit_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    poll_d = rd_en && busy;
    hit_d  = rd_en && !busy && id_mode && (rd_addr[ADDR_W-1:1] == '0);
    data_d = '0;
    if (hit_d) data_d = rd_addr[0] ? DEV_CODE : MFR_CODE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      poll_q  <= 1'b0;
      hit_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= rd_en;
      poll_q  <= poll_d;
      hit_q   <= hit_d;
      data_q  <= data_d;
    end
  end

  assign rd_valid  = valid_q;
  assign rd_poll   = poll_q;
  assign rd_id_hit = hit_q;
  assign rd_data   = data_q;

  assert_hit_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_id_hit |-> $past(id_mode) && !$past(busy) && rd_valid);
  assert_poll_excludes_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_poll |-> !rd_id_hit && rd_data == '0);
endmodule

// File: rtl/flash_unlock_decoder.sv
module flash_unlock_decoder
  import fcd_pkg::*;
#(
  parameter int                WAIT_CYCLES = 16,
  parameter logic [DATA_W-1:0] MFR_CODE    = 8'h1F,
  parameter logic [DATA_W-1:0] DEV_CODE    = 8'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_end,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              prog_go,
  output logic              id_mode,
  output logic              bad_write,
  output logic              busy,
  output logic              rd_valid,
  output logic              rd_poll,
  output logic              rd_id_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic [1:0] rst_pipe_q;
  logic       rst_local_n;
  logic       key1_ok, key2_ok, timer_start, busy_w;
  cmd_op_e    op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_local_n = rst_pipe_q[1];

  fcd_cmd_matcher u_match (
    .addr    (wr_addr),
    .data    (wr_data),
    .key1_ok (key1_ok),
    .key2_ok (key2_ok),
    .op      (op)
  );

  fcd_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_local_n),
    .start (timer_start),
    .busy  (busy_w)
  );

  fcd_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_local_n),
    .wr_valid    (wr_valid),
    .busy        (busy_w),
    .key1_ok     (key1_ok),
    .key2_ok     (key2_ok),
    .op          (op),
    .prog_end    (prog_end),
    .timer_start (timer_start),
    .prog_go     (prog_go),
    .bad_write   (bad_write),
    .id_mode     (id_mode)
  );

  fcd_id_responder #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .clk       (clk),
    .rst_n     (rst_local_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .id_mode   (id_mode),
    .busy      (busy_w),
    .rd_valid  (rd_valid),
    .rd_poll   (rd_poll),
    .rd_id_hit (rd_id_hit),
    .rd_data   (rd_data)
  );

  assign busy = busy_w;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_local_n |-> !prog_go && !bad_write && !id_mode && !busy);
endmodule

// File: tb/flash_unlock_decoder_bench.sv
module flash_unlock_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT       = 8;
  localparam int NVEC       = 20;

  // {addr[15], data[8], exp_prog, exp_bad, exp_id, wait_busy, end_prog}
  localparam logic [27:0] VEC [NVEC] = '{
    {15'h5555, 8'hAA, 5'b00000},
    {15'h2AAA, 8'h55, 5'b00000},
    {15'h5555, 8'h90, 5'b00110},
    {15'h5555, 8'hAA, 5'b00100},
    {15'h2AAA, 8'h55, 5'b00100},
    {15'h5555, 8'hA0, 5'b10101},
    {15'h5555, 8'hAA, 5'b00100},
    {15'h2AAA, 8'h55, 5'b00100},
    {15'h5555, 8'hF0, 5'b00010},
    {15'h5555, 8'hAA, 5'b00000},
    {15'h2AAA, 8'h55, 5'b00000},
    {15'h5555, 8'hA0, 5'b10001},
    {15'h1234, 8'h12, 5'b01010},
    {15'h5555, 8'hAA, 5'b00000},
    {15'h1111, 8'h55, 5'b01010},
    {15'h5555, 8'hAA, 5'b00000},
    {15'h2AAA, 8'h55, 5'b00000},
    {15'h5555, 8'h77, 5'b01010},
    {15'h4555, 8'hAA, 5'b01010},
    {15'h5555, 8'h55, 5'b01010}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        prog_end = 1'b0;
  logic        rd_en = 1'b0;
  logic [14:0] rd_addr = '0;
  logic        prog_go, id_mode, bad_write, busy, rd_valid, rd_poll, rd_id_hit;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_unlock_decoder #(.WAIT_CYCLES(WAIT)) u_flash_unlock_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_end(prog_end), .rd_en(rd_en), .rd_addr(rd_addr),
    .prog_go(prog_go), .id_mode(id_mode), .bad_write(bad_write), .busy(busy),
    .rd_valid(rd_valid), .rd_poll(rd_poll), .rd_id_hit(rd_id_hit), .rd_data(rd_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic end_prog();
    @(negedge clk);
    prog_end = 1'b1;
    @(negedge clk);
    prog_end = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    repeat (WAIT) @(negedge clk);
    chk(req, "busy after window", int'(busy), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1", "id_mode", int'(id_mode), 0);
    chk("R1", "prog_go", int'(prog_go), 0);
    chk("R1", "bad_write", int'(bad_write), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);

    // Vector table: R2 R4 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [27:0] v;
      v = VEC[i];
      wr(v[27:13], v[12:5]);
      chk("R2", $sformatf("vec%0d prog_go", i), int'(prog_go), int'(v[4]));
      chk("R6", $sformatf("vec%0d bad_write", i), int'(bad_write), int'(v[3]));
      chk("R4", $sformatf("vec%0d id_mode", i), int'(id_mode), int'(v[2]));
      if (v[1]) begin
        chk("R7", $sformatf("vec%0d busy", i), int'(busy), 1);
        wait_idle("R7");
      end
      if (v[0]) begin
        @(negedge clk);
        chk("R2", $sformatf("vec%0d pulse width", i), int'(prog_go), 0);
        end_prog();
      end
    end

    // R5 identification codes
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
    wait_idle("R7");
    rd(15'h0000);
    chk("R5", "valid", int'(rd_valid), 1);
    chk("R5", "hit mfr", int'(rd_id_hit), 1);
    chk("R5", "mfr code", int'(rd_data), 'h1F);
    rd(15'h0001);
    chk("R5", "hit dev", int'(rd_id_hit), 1);
    chk("R5", "dev code", int'(rd_data), 'h3D);
    rd(15'h0002);
    chk("R5", "upper addr hit", int'(rd_id_hit), 0);
    chk("R5", "upper addr data", int'(rd_data), 0);

    // R8 read during busy
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hF0);
    rd(15'h0000);
    chk("R8", "poll", int'(rd_poll), 1);
    chk("R8", "hit", int'(rd_id_hit), 0);
    repeat (WAIT) @(negedge clk);
    chk("R4", "id after exit", int'(id_mode), 0);
    rd(15'h0000);
    chk("R5", "hit outside id", int'(rd_id_hit), 0);
    chk("R8", "no poll when idle", int'(rd_poll), 0);

    // R7 writes during busy are dropped
    wr(15'h1234, 8'h12);
    chk("R6", "bad pulse", int'(bad_write), 1);
    wr(15'h5555, 8'hAA);
    chk("R7", "no pulse under busy", int'(bad_write), 0);
    wr(15'h2AAA, 8'h55);
    wr(15'h5555, 8'h90);
    chk("R7", "no bad under busy", int'(bad_write), 0);
    repeat (WAIT) @(negedge clk);
    chk("R7", "id unchanged", int'(id_mode), 0);
    chk("R7", "busy cleared", int'(busy), 0);

    // R3 loader ownership and return to protection
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
    chk("R2", "grant", int'(prog_go), 1);
    wr(15'h1234, 8'h12);
    chk("R3", "load no bad", int'(bad_write), 0);
    chk("R3", "load no busy", int'(busy), 0);
    wr(15'h5555, 8'hA0);
    chk("R3", "load no grant", int'(prog_go), 0);
    end_prog();
    wr(15'h5555, 8'hA0);
    chk("R3", "protected again", int'(bad_write), 1);
    chk("R3", "no grant", int'(prog_go), 0);
    wait_idle("R7");

    // R9 reset clears id mode, keeps protection
    wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h90);
    wait_idle("R7");
    chk("R4", "id set", int'(id_mode), 1);
    rst_n = 1'b0;
    #1;
    chk("R9", "id cleared", int'(id_mode), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    wr(15'h5555, 8'hA0);
    chk("R9", "lone grant rejected", int'(bad_write), 1);
    chk("R9", "no grant", int'(prog_go), 0);
    wait_idle("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule